// File: doc/BRIEF.md
# Multi-Channel Receive Frame Dispatcher

This block sits behind the receive MAC and its frame check. Validated Ethernet frames arrive one byte per cycle, marked with start and end flags. The block reads each frame's destination address and compares it with one 48-bit address per channel, for up to eight channels. It then hands the whole frame to the container assembler of every selected channel. The output is a single byte stream plus a channel bit mask, which tells each assembler whether the current byte belongs to it.

Three configuration inputs control admission: a global on switch, a per-channel enable mask and a broadcast enable. Each assembler reports through a space input whether it has a free container. A frame that finds no eligible channel is discarded. So is a frame whose eligible channels are all full. Each of these two causes has its own saturating statistics counter. Two more counters track the frames seen and the broadcast frames seen. Software can overwrite any of the four counters.

The header is held in a fixed six-stage byte pipeline until the routing decision is known. The output therefore follows the input with a constant six-cycle delay. Within a frame, bytes must arrive on consecutive cycles.

Top module: `rx_frame_dispatcher`

## Requirements
- R1: After synchronous active-low reset, `out_valid`, `out_sof`, `out_eof`, `out_ch` and `out_data` are zero, and all four counters are zero.
- R2: A byte presented with `in_valid` in cycle c appears on `out_data` in cycle c+6, with the same start and end flags. It appears only if its frame has at least one target channel; otherwise the outputs stay zero.
- R3: While `cfg_on` is 0 when a frame's sixth byte is presented, that frame produces no output and changes no counter.
- R4: The destination address is bytes 0 to 5 of the frame, byte 0 being the most significant. Channel i owns address `ch_mac[48*i+47:48*i]`. A unicast frame is delivered on `out_ch` bit i for every channel i that is enabled in `cfg_ch_en`, whose address matches, and whose `ch_space` bit is set.
- R5: `cnt_rx` increases by one for each frame of at least six bytes accepted while on. The new value is visible in the cycle after the sixth byte.
- R6: A frame with no candidate channel is dropped and `cnt_dst_fail` increases by one. This covers a unicast frame with no enabled matching channel, and a broadcast frame while `cfg_bc_en` is 0 or while no channel is enabled.
- R7: A frame that has candidate channels, none of which has its `ch_space` bit set in the sixth-byte cycle, is dropped and `cnt_ch_full` increases by one. Never both R6 and R7 for one frame.
- R8: `cnt_bc` increases by one for every accepted frame whose destination is all ones, whether or not broadcast is enabled.
- R9: With `cfg_bc_en` set, an all-ones destination is delivered to every enabled channel that has space.
- R10: A frame that ends before its sixth byte produces no output and changes no counter.
- R11: Every counter saturates at all ones and holds there.
- R12: `cnt_wr_en` loads `cnt_wr_data` into the counter chosen by `cnt_wr_sel` (0 received, 1 broadcast, 2 destination failure, 3 channel full). The new value is visible in the next cycle, and a write wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| ch_space | input | NUM_CH | Per-channel free container available |
| cfg_on | input | 1 | Global enable |
| cfg_ch_en | input | NUM_CH | Per-channel enable mask |
| cfg_bc_en | input | 1 | Broadcast acceptance |
| ch_mac | input | 48*NUM_CH | Channel addresses, channel i at bits 48*i+47:48*i |
| cnt_wr_en | input | 1 | Counter write strobe |
| cnt_wr_sel | input | 2 | Counter to write |
| cnt_wr_data | input | CNT_W | Counter write value |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | First byte of delivered frame |
| out_eof | output | 1 | Last byte of delivered frame |
| out_data | output | 8 | Delivered byte |
| out_ch | output | NUM_CH | Target channel mask for the current byte |
| cnt_rx | output | CNT_W | Frames received |
| cnt_bc | output | CNT_W | Broadcast frames received |
| cnt_dst_fail | output | CNT_W | Frames dropped for no candidate channel |
| cnt_ch_full | output | CNT_W | Frames dropped for no free container |

## Verification
Each byte's expected output is due exactly six cycles after it is presented. The bench records the input and the bench-computed target mask at every clock edge in an eight-entry history, then compares the outputs two nanoseconds after each edge against the entry from five edges earlier. Counter effects are due one cycle after the sixth byte, and software writes one cycle after the strobe. The counters are compared only after the frame has ended and two idle cycles have passed, which leaves margin for both.

// File: rtl/rxd_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types of the receive dispatcher.
// Assumes byte-wide frames with a 48-bit destination address in front.
package rxd_pkg;
    localparam int MAC_W     = 48;
    localparam int HDR_BYTES = MAC_W / 8;
    localparam int NUM_CNT   = 4;

    typedef enum logic [1:0] {
        SEL_RX   = 2'd0,
        SEL_BC   = 2'd1,
        SEL_DST  = 2'd2,
        SEL_FULL = 2'd3
    } cnt_sel_e;

    typedef struct packed {
        logic       valid;
        logic       sof;
        logic       eof;
        logic [7:0] data;
    } beat_t;

    localparam logic [MAC_W-1:0] BCAST_ADDR = '1;
endpackage

// File: rtl/rxd_hdr_capture.sv
`timescale 1ns/1ps
// Module: tracks frame position and gathers the destination address.
// Assumes each frame starts with in_sof. Bytes outside a frame are ignored.
// decide pulses with the sixth byte, and dst is valid in that cycle.
module rxd_hdr_capture
    import rxd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    output logic             accept,
    output logic             decide,
    output logic             early,
    output logic [MAC_W-1:0] dst
);
    localparam int IDX_W = $clog2(HDR_BYTES + 1);
    localparam logic [IDX_W-1:0] LAST_HDR = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] PAST_HDR = IDX_W'(HDR_BYTES);

    logic             in_frame_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] cur_idx;
    logic [MAC_W-9:0] prev_q;

    // Classify the incoming byte by its position in the frame.
    always_comb begin
        accept  = in_valid && (in_sof || in_frame_q);
        cur_idx = in_sof ? '0 : idx_q;
        decide  = accept && (cur_idx == LAST_HDR);
        early   = accept && (cur_idx < LAST_HDR);
        dst     = {prev_q, in_data};
    end

    // Advance the position counter and shift header bytes in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            idx_q      <= '0;
            prev_q     <= '0;
        end else if (accept) begin
            in_frame_q <= !in_eof;
            idx_q      <= (cur_idx == PAST_HDR) ? cur_idx : cur_idx + IDX_W'(1);
            prev_q     <= {prev_q[MAC_W-17:0], in_data};
        end
    end
endmodule

// File: rtl/rxd_dst_match.sv
`timescale 1ns/1ps
// Module: routing decision for one destination address (combinational).
// Candidates are the enabled channels whose address matches, or, for a
// broadcast with broadcast enabled, all enabled channels. Targets are
// the candidates that have space.
module rxd_dst_match
    import rxd_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [MAC_W-1:0]        dst,
    input  logic [NUM_CH*MAC_W-1:0] ch_mac,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic                    bc_en,
    input  logic [NUM_CH-1:0]       space,
    output logic [NUM_CH-1:0]       tgt,
    output logic                    is_bc,
    output logic                    dst_fail,
    output logic                    ch_full
);
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] cand;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
        // Compare against channel i's address.
        assign hit[i] = (ch_mac[i*MAC_W +: MAC_W] == dst);
    end

    // Reduce matches to candidates, targets and discard cause.
    always_comb begin
        is_bc    = (dst == BCAST_ADDR);
        cand     = is_bc ? (bc_en ? ch_en : '0) : (ch_en & hit);
        tgt      = cand & space;
        dst_fail = (cand == '0);
        ch_full  = (cand != '0) && (tgt == '0);
    end
endmodule

// File: rtl/rxd_delay_line.sv
`timescale 1ns/1ps
// Module: fixed-depth byte pipeline that holds the header until routing is
// known. Bytes entering before the decision are marked pending. When
// resolve is asserted, every pending byte takes the resolved target mask.
module rxd_delay_line
    import rxd_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DEPTH  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  beat_t             in_beat,
    input  logic [NUM_CH-1:0] in_tgt,
    input  logic              in_pend,
    input  logic              resolve,
    input  logic [NUM_CH-1:0] resolve_tgt,
    output beat_t             out_beat,
    output logic [NUM_CH-1:0] out_tgt
);
    beat_t             beat_q [DEPTH];
    logic [NUM_CH-1:0] tgt_q  [DEPTH];
    logic              pend_q [DEPTH];

    // Shift all stages, resolving pending target masks on the way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                beat_q[i] <= '0;
                tgt_q[i]  <= '0;
                pend_q[i] <= 1'b0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                beat_t             pb;
                logic [NUM_CH-1:0] pt;
                logic              pp;
                pb = (i == 0) ? in_beat : beat_q[(i == 0) ? 0 : i-1];
                pt = (i == 0) ? in_tgt  : tgt_q[(i == 0) ? 0 : i-1];
                pp = (i == 0) ? in_pend : pend_q[(i == 0) ? 0 : i-1];
                beat_q[i] <= pb;
                if (resolve && pp) begin
                    tgt_q[i]  <= resolve_tgt;
                    pend_q[i] <= 1'b0;
                end else begin
                    tgt_q[i]  <= pt;
                    pend_q[i] <= pp;
                end
            end
        end
    end

    // Present the last stage.
    always_comb begin
        out_beat = beat_q[DEPTH-1];
        out_tgt  = tgt_q[DEPTH-1];
    end
endmodule

// File: rtl/rxd_sat_counter.sv
`timescale 1ns/1ps
// Module: saturating event counter with a software load.
// A load wins over an increment in the same cycle.
module rxd_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value
);
    // Load, count up, or hold at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (wr)
            value <= wr_data;
        else if (inc && (value != '1))
            value <= value + W'(1);
    end
endmodule

// File: rtl/rx_frame_dispatcher.sv
`timescale 1ns/1ps
// Module: top of the receive frame dispatcher. Routes each frame to the
// channels selected by its destination address and counts events.
// Assumes bytes of one frame arrive on consecutive cycles, and that the
// configuration is stable while a frame's header passes.
module rx_frame_dispatcher
    import rxd_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic                    in_eof,
    input  logic [7:0]              in_data,
    input  logic [NUM_CH-1:0]       ch_space,
    input  logic                    cfg_on,
    input  logic [NUM_CH-1:0]       cfg_ch_en,
    input  logic                    cfg_bc_en,
    input  logic [NUM_CH*MAC_W-1:0] ch_mac,
    input  logic                    cnt_wr_en,
    input  logic [1:0]              cnt_wr_sel,
    input  logic [CNT_W-1:0]        cnt_wr_data,
    output logic                    out_valid,
    output logic                    out_sof,
    output logic                    out_eof,
    output logic [7:0]              out_data,
    output logic [NUM_CH-1:0]       out_ch,
    output logic [CNT_W-1:0]        cnt_rx,
    output logic [CNT_W-1:0]        cnt_bc,
    output logic [CNT_W-1:0]        cnt_dst_fail,
    output logic [CNT_W-1:0]        cnt_ch_full
);
    logic              accept, decide, early;
    logic [MAC_W-1:0]  dst;
    logic [NUM_CH-1:0] m_tgt, eff_tgt, cur_tgt_q, line_tgt, dl_tgt;
    logic              m_is_bc, m_dst_fail, m_ch_full;
    beat_t             in_beat, dl_beat;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0]  cnt_val [NUM_CNT];

    rxd_hdr_capture u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .in_data  (in_data),
        .accept   (accept),
        .decide   (decide),
        .early    (early),
        .dst      (dst)
    );

    rxd_dst_match #(.NUM_CH(NUM_CH)) u_match (
        .dst      (dst),
        .ch_mac   (ch_mac),
        .ch_en    (cfg_ch_en),
        .bc_en    (cfg_bc_en),
        .space    (ch_space),
        .tgt      (m_tgt),
        .is_bc    (m_is_bc),
        .dst_fail (m_dst_fail),
        .ch_full  (m_ch_full)
    );

    // Form the pipeline input and the counter events.
    always_comb begin
        eff_tgt      = cfg_on ? m_tgt : '0;
        in_beat      = '{valid: accept, sof: in_sof && accept,
                         eof: in_eof && accept, data: in_data};
        line_tgt     = decide ? eff_tgt : (early ? '0 : cur_tgt_q);
        cnt_inc[SEL_RX]   = decide && cfg_on;
        cnt_inc[SEL_BC]   = decide && cfg_on && m_is_bc;
        cnt_inc[SEL_DST]  = decide && cfg_on && m_dst_fail;
        cnt_inc[SEL_FULL] = decide && cfg_on && m_ch_full;
    end

    // Hold the routing of the current frame for its body bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_tgt_q <= '0;
        else if (decide)
            cur_tgt_q <= eff_tgt;
    end

    rxd_delay_line #(.NUM_CH(NUM_CH), .DEPTH(HDR_BYTES)) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_beat     (in_beat),
        .in_tgt      (line_tgt),
        .in_pend     (early),
        .resolve     (decide),
        .resolve_tgt (eff_tgt),
        .out_beat    (dl_beat),
        .out_tgt     (dl_tgt)
    );

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        rxd_sat_counter #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (cnt_inc[k]),
            .wr      (cnt_wr_en && (cnt_wr_sel == 2'(k))),
            .wr_data (cnt_wr_data),
            .value   (cnt_val[k])
        );
    end

    // Gate the pipeline output with its target mask.
    always_comb begin
        out_valid    = dl_beat.valid && (dl_tgt != '0);
        out_sof      = out_valid && dl_beat.sof;
        out_eof      = out_valid && dl_beat.eof;
        out_data     = out_valid ? dl_beat.data : 8'h00;
        out_ch       = out_valid ? dl_tgt : '0;
        cnt_rx       = cnt_val[SEL_RX];
        cnt_bc       = cnt_val[SEL_BC];
        cnt_dst_fail = cnt_val[SEL_DST];
        cnt_ch_full  = cnt_val[SEL_FULL];
    end
endmodule

// File: rtl/rxd_checker.sv
`timescale 1ns/1ps
// Module: temporal properties of the receive dispatcher, bound to the top.
module rxd_checker #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [7:0]       in_data,
    input logic             cfg_on,
    input logic             cnt_wr_en,
    input logic [1:0]       cnt_wr_sel,
    input logic [CNT_W-1:0] cnt_wr_data,
    input logic             out_valid,
    input logic [7:0]       out_data,
    input logic [CNT_W-1:0] cnt_rx,
    input logic [CNT_W-1:0] cnt_bc,
    input logic [CNT_W-1:0] cnt_dst_fail,
    input logic [CNT_W-1:0] cnt_ch_full
);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid, 6) && (out_data == $past(in_data, 6))));

    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_on && !cnt_wr_en) |=> ((cnt_rx == $past(cnt_rx)) && (cnt_bc == $past(cnt_bc))
            && (cnt_dst_fail == $past(cnt_dst_fail)) && (cnt_ch_full == $past(cnt_ch_full))));

    p_rx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr_en |=> ((cnt_rx == $past(cnt_rx)) || (cnt_rx == $past(cnt_rx) + CNT_W'(1))));

    p_drop_counted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr_en && (cnt_rx != '1)) |=>
            ((cnt_dst_fail == $past(cnt_dst_fail)) || (cnt_rx == $past(cnt_rx) + CNT_W'(1))));

    p_one_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr_en |=> !((cnt_dst_fail != $past(cnt_dst_fail)) && (cnt_ch_full != $past(cnt_ch_full))));

    p_sat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_rx == '1) && !cnt_wr_en) |=> (cnt_rx == '1));

    p_write_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr_en && (cnt_wr_sel == 2'd3)) |=> (cnt_ch_full == $past(cnt_wr_data)));
endmodule

bind rx_frame_dispatcher rxd_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .cfg_on       (cfg_on),
    .cnt_wr_en    (cnt_wr_en),
    .cnt_wr_sel   (cnt_wr_sel),
    .cnt_wr_data  (cnt_wr_data),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .cnt_rx       (cnt_rx),
    .cnt_bc       (cnt_bc),
    .cnt_dst_fail (cnt_dst_fail),
    .cnt_ch_full  (cnt_ch_full)
);

// File: tb/rx_frame_dispatcher_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random frames, with the output
// stream and counters compared to bench-computed expectations.
module rx_frame_dispatcher_tb;
    localparam int NUM_CH = 4;
    localparam int CNT_W  = 32;
    localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]             in_data = 8'h00;
    logic [NUM_CH-1:0]      ch_space = '0;
    logic                   cfg_on = 1'b0;
    logic [NUM_CH-1:0]      cfg_ch_en = '0;
    logic                   cfg_bc_en = 1'b0;
    logic [NUM_CH*48-1:0]   ch_mac;
    logic                   cnt_wr_en = 1'b0;
    logic [1:0]             cnt_wr_sel = 2'd0;
    logic [CNT_W-1:0]       cnt_wr_data = '0;
    logic                   out_valid, out_sof, out_eof;
    logic [7:0]             out_data;
    logic [NUM_CH-1:0]      out_ch;
    logic [CNT_W-1:0]       cnt_rx, cnt_bc, cnt_dst_fail, cnt_ch_full;

    int checks = 0;
    int errors = 0;
    logic [47:0]       mac_tb [NUM_CH];
    logic [31:0]       exp_cnt [4];
    logic [NUM_CH-1:0] tb_tgt = '0;
    string             tb_tag = "R2";

    always #4 clk = ~clk;

    rx_frame_dispatcher #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .ch_space(ch_space), .cfg_on(cfg_on), .cfg_ch_en(cfg_ch_en),
        .cfg_bc_en(cfg_bc_en), .ch_mac(ch_mac), .cnt_wr_en(cnt_wr_en),
        .cnt_wr_sel(cnt_wr_sel), .cnt_wr_data(cnt_wr_data), .out_valid(out_valid),
        .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data), .out_ch(out_ch),
        .cnt_rx(cnt_rx), .cnt_bc(cnt_bc), .cnt_dst_fail(cnt_dst_fail),
        .cnt_ch_full(cnt_ch_full)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sat_inc(input logic [31:0] v);
        return (v == 32'hFFFF_FFFF) ? v : v + 32'd1;
    endfunction

    // Expected routing per R4, R6, R7, R9.
    task automatic f_decide(input logic [47:0] dst, input logic [NUM_CH-1:0] sp,
                            output logic [NUM_CH-1:0] tgt, output bit bc, output bit df, output bit cf);
        logic [NUM_CH-1:0] cand;
        bc = (dst == BC);
        cand = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (cfg_ch_en[i] && (bc ? cfg_bc_en : (mac_tb[i] == dst))) cand[i] = 1'b1;
        tgt = cand & sp;
        df  = (cand == '0);
        cf  = (cand != '0) && (tgt == '0);
    endtask

    // Output history: input seen at each edge with its expected targets.
    logic [31:0]       cyc = 0;
    bit                h_v [8], h_s [8], h_e [8];
    logic [7:0]        h_d [8];
    logic [NUM_CH-1:0] h_t [8];
    string             h_tag [8];
    always @(posedge clk) begin
        logic [2:0] wi, ri;
        bit ev;
        #2;
        wi = cyc[2:0];
        h_v[wi] = in_valid && rst_n;
        h_s[wi] = in_sof; h_e[wi] = in_eof; h_d[wi] = in_data;
        h_t[wi] = tb_tgt; h_tag[wi] = tb_tag;
        if (cyc >= 5 && rst_n) begin
            ri = 3'(cyc - 32'd5);
            ev = h_v[ri] && (h_t[ri] != '0);
            if (ev || out_valid)
                chk(ev == out_valid && (!ev || (out_ch == h_t[ri] && out_data == h_d[ri]
                    && out_sof == h_s[ri] && out_eof == h_e[ri])),
                    {h_tag[ri], " R2 output stream"},
                    {out_valid, out_sof, out_eof, out_ch, out_data},
                    {ev, h_s[ri], h_e[ri], h_t[ri], h_d[ri]});
        end
        cyc++;
    end

    task automatic check_counters(input string tag);
        chk(cnt_rx == exp_cnt[0], {tag, " R5 cnt_rx"}, cnt_rx, exp_cnt[0]);
        chk(cnt_bc == exp_cnt[1], {tag, " R8 cnt_bc"}, cnt_bc, exp_cnt[1]);
        chk(cnt_dst_fail == exp_cnt[2], {tag, " R6 cnt_dst_fail"}, cnt_dst_fail, exp_cnt[2]);
        chk(cnt_ch_full == exp_cnt[3], {tag, " R7 cnt_ch_full"}, cnt_ch_full, exp_cnt[3]);
    endtask

    task automatic send_frame(input logic [47:0] dst, input int len, input logic [NUM_CH-1:0] sp,
                              input string tag, input bit wr5 = 1'b0,
                              input logic [1:0] wsel = 2'd0, input logic [31:0] wval = 32'd0);
        logic [NUM_CH-1:0] t;
        bit bc, df, cf;
        f_decide(dst, sp, t, bc, df, cf);
        if (len >= 6 && cfg_on) begin
            exp_cnt[0] = sat_inc(exp_cnt[0]);
            if (bc) exp_cnt[1] = sat_inc(exp_cnt[1]);
            if (df) exp_cnt[2] = sat_inc(exp_cnt[2]);
            if (cf) exp_cnt[3] = sat_inc(exp_cnt[3]);
            tb_tgt = t;
        end else begin
            tb_tgt = '0;
        end
        if (wr5 && len >= 6) exp_cnt[wsel] = wval;
        tb_tag = tag;
        ch_space = sp;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof = (i == 0);
            in_eof = (i == len - 1);
            in_data = (i < 6) ? dst[47 - 8*i -: 8] : 8'($urandom);
            cnt_wr_en = wr5 && (i == 5);
            cnt_wr_sel = wsel;
            cnt_wr_data = wval;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; cnt_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        check_counters(tag);
    endtask

    task automatic sw_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cnt_wr_en = 1'b1; cnt_wr_sel = sel; cnt_wr_data = val;
        @(negedge clk);
        cnt_wr_en = 1'b0;
        exp_cnt[sel] = val;
        check_counters("R12 write");
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NUM_CH; i++) begin
            mac_tb[i] = 48'h02_11_22_33_44_00 + 48'(i * 3 + 1);
            ch_mac[i*48 +: 48] = mac_tb[i];
        end
        for (int k = 0; k < 4; k++) exp_cnt[k] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk({out_valid, out_sof, out_eof, out_ch, out_data} == '0, "R1 outputs after reset",
            {out_valid, out_ch, out_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_counters("R1");

        // R3: globally off, nothing passes or counts
        cfg_ch_en = '1; cfg_bc_en = 1'b1; cfg_on = 1'b0;
        send_frame(mac_tb[0], 10, '1, "R3");
        cfg_on = 1'b1;
        // R4: unicast to one channel
        send_frame(mac_tb[2], 12, '1, "R4");
        // R6: matching channel disabled
        cfg_ch_en = 4'b1011;
        send_frame(mac_tb[2], 9, '1, "R6");
        // R7: matched channel without space
        send_frame(mac_tb[1], 8, 4'b1101, "R7");
        // R8 and R6: broadcast refused
        cfg_bc_en = 1'b0;
        send_frame(BC, 7, '1, "R8");
        // R9: broadcast fan-out
        cfg_bc_en = 1'b1;
        send_frame(BC, 15, 4'b1110, "R9");
        send_frame(BC, 6, 4'b0100, "R9 full");
        // R10: runt frame
        send_frame(mac_tb[0], 4, '1, "R10");
        send_frame(mac_tb[3], 1, '1, "R10 single");
        // R11: saturation
        sw_write(2'd0, 32'hFFFF_FFFF);
        send_frame(mac_tb[0], 8, '1, "R11");
        sw_write(2'd3, 32'hFFFF_FFFE);
        send_frame(mac_tb[3], 6, 4'b0000, "R11 full");
        send_frame(mac_tb[3], 6, 4'b0000, "R11 full hold");
        // R12: write beats increment in the same cycle
        sw_write(2'd0, 32'd7);
        send_frame(mac_tb[1], 9, '1, "R12 race", 1'b1, 2'd0, 32'd100);
        send_frame(48'h0A0B0C0D0E0F, 9, '1, "R12 race dst", 1'b1, 2'd2, 32'd55);

        // Random traffic
        for (int n = 0; n < 200; n++) begin
            logic [47:0] d;
            int len;
            cfg_ch_en = NUM_CH'($urandom);
            cfg_bc_en = 1'($urandom);
            cfg_on = ($urandom % 8) != 0;
            case ($urandom % 4)
                0, 1: d = mac_tb[$urandom % NUM_CH];
                2: d = BC;
                default: d = {16'($urandom), 32'($urandom)};
            endcase
            len = ($urandom % 10 == 0) ? 1 + int'($urandom % 5) : 6 + int'($urandom % 19);
            send_frame(d, len, NUM_CH'($urandom), "R4 R9 random");
            if ($urandom % 12 == 0) sw_write(2'($urandom), 32'($urandom % 1000));
        end
        repeat (8) @(negedge clk);
        finish_run();
    end
endmodule